// File: doc/BRIEF.md
# Event-Driven Configurable Counter

A 32-bit up/down counter with a single-cycle event path. In normal operation the count steps by one on every clock where the enable is high. The direction input picks increment or decrement, and the count wraps modulo 2^32 in both directions.

A rising edge on the event input replaces that cycle's step with one configured operation. The operation is one of:
- load a preset value
- shift the count left or right by the low five bits of the preset
- add the preset to the count
- subtract the preset from the count

Three static configuration bits choose the operation. After the event cycle, normal counting resumes.

The block compares the registered count against two reference registers and against zero, and drives three flags from those compares. The preset and both references are loaded through a small write port. They may be set once before operation or changed at run time. A level-sensitive clear has priority over everything else.

Top module: `evc_counter`

## Requirements
- R1: While `clr` is high at a clock edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: With no event edge and `cnt_en` low, `count` keeps its value.
- R3: With no event edge and `cnt_en` high, `count` rises by one when `cnt_up` is 1 and falls by one when `cnt_up` is 0.
- R4: Counting wraps: up from 0xFFFFFFFF gives 0, and down from 0 gives 0xFFFFFFFF.
- R5: An event edge is `evt` sampled high at a clock edge when it was sampled low at the previous edge. Holding `evt` high starts no further event.
- R6: In an event-edge cycle the event operation replaces the count step, whatever `cnt_en` and `cnt_up` are. In the following cycle normal counting applies again.
- R7: With `cfg_arith`=0, an event loads the preset into `count`.
- R8: With `cfg_arith`=1 and `cfg_add`=0, an event shifts `count` left when `cfg_left`=1 and right when `cfg_left`=0. The shift is logical, zero-filled, and by preset[4:0].
- R9: With `cfg_arith`=1 and `cfg_add`=1, an event adds the full preset when `cfg_left`=1 and subtracts it when `cfg_left`=0. Both are unsigned and wrap with no saturation.
- R10: `zero_o`, `hit1` and `hit2` are high in the same cycle that `count` equals 0, reference 1 or reference 2 respectively.
- R11: A write with `wr_en`=1 stores `wr_data` on the next edge, into the preset when `wr_sel`=0, reference 1 when `wr_sel`=1, and reference 2 when `wr_sel`=2. `wr_sel`=3 changes nothing. An event in the same cycle as a preset write uses the old preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Level-sensitive clear of the count, highest priority |
| cnt_en | input | 1 | Count enable |
| cnt_up | input | 1 | Count direction, 1 = up |
| evt | input | 1 | Event input, rising edge active |
| cfg_arith | input | 1 | Event kind: 0 = load preset, 1 = shift or add/subtract |
| cfg_add | input | 1 | 1 = add/subtract, 0 = shift |
| cfg_left | input | 1 | 1 = left shift or add, 0 = right shift or subtract |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 preset, 1 reference 1, 2 reference 2, 3 none |
| wr_data | input | 32 | Write data |
| count | output | 32 | Registered count |
| zero_o | output | 1 | Count equals zero |
| hit1 | output | 1 | Count equals reference 1 |
| hit2 | output | 1 | Count equals reference 2 |

## Verification
Some properties are checked by assertions on every cycle:
- the clear forcing zero
- the hold and the single step in each direction
- the load of the preset on an event
- the one-cycle width of the detected edge
- the storing of writes

Other behaviour shows only in the bench scenarios:
- the wrap values at both ends
- each shift and add/subtract result, including a shift amount of 31 and of 0
- the flags following a reference that changes at run time
- the same-cycle write and event ordering
- the ignored select code

// File: rtl/evc_pkg.sv
package evc_pkg;
  parameter int CNT_W = 32;
  localparam int SH_W = $clog2(CNT_W);

  typedef enum logic [1:0] {
    SEL_PRESET = 2'd0,
    SEL_REF1   = 2'd1,
    SEL_REF2   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_t;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_SHR  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SUB  = 3'd3,
    OP_ADD  = 3'd4
  } ev_op_t;

  function automatic ev_op_t decode_op(input logic arith, input logic add, input logic left);
    if (!arith)     return OP_LOAD;
    else if (!add)  return left ? OP_SHL : OP_SHR;
    else            return left ? OP_ADD : OP_SUB;
  endfunction

  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] cur, input logic up);
    return up ? cur + 1'b1 : cur - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] event_val(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] pre,
                                                 input ev_op_t op);
    logic [SH_W-1:0] amt;
    amt = pre[SH_W-1:0];
    case (op)
      OP_SHR:  return cur >> amt;
      OP_SHL:  return cur << amt;
      OP_SUB:  return cur - pre;
      OP_ADD:  return cur + pre;
      default: return pre;
    endcase
  endfunction
endpackage

// File: rtl/evc_edge.sv
module evc_edge (
  input  logic clk,
  input  logic clr,
  input  logic evt,
  output logic pulse
);
  logic evt_q;

  always_ff @(posedge clk) begin
    evt_q <= evt;
  end

  assign pulse = evt & ~evt_q;

  // R5 / R6: a detected edge never lasts two cycles
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (clr)
    pulse |=> !pulse)
    else $error("edge pulse held for two cycles");
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] ref1,
  output logic [CNT_W-1:0] ref2
);
  logic do_pre, do_r1, do_r2;

  assign do_pre = wr_en && (wr_sel == SEL_PRESET);
  assign do_r1  = wr_en && (wr_sel == SEL_REF1);
  assign do_r2  = wr_en && (wr_sel == SEL_REF2);

  always_ff @(posedge clk) begin
    if (do_pre) preset <= wr_data;
    if (do_r1)  ref1   <= wr_data;
    if (do_r2)  ref2   <= wr_data;
  end

  p_write_pre_r11: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_sel == 2'd0) |=> preset == $past(wr_data))
    else $error("preset write lost");
  p_write_none_r11: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_sel == 2'd3) |=> ($stable(preset) && $stable(ref1) && $stable(ref2)))
    else $error("select 3 changed a register");
endmodule

// File: rtl/evc_core.sv
module evc_core
  import evc_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             pulse,
  input  ev_op_t           op,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (pulse)       nxt = event_val(count, preset, op);
    else if (cnt_en) nxt = step_val(count, cnt_up);
    else             nxt = count;
  end

  always_ff @(posedge clk) begin
    if (clr) count <= '0;
    else     count <= nxt;
  end

  // R1: clear wins over everything
  p_clear_r1: assert property (@(posedge clk)
    $past(clr) |-> count == '0)
    else $error("clear did not zero count");
  p_hold_r2: assert property (@(posedge clk) disable iff (clr)
    (!pulse && !cnt_en) |=> $stable(count))
    else $error("count moved while disabled");
  p_up_r3: assert property (@(posedge clk) disable iff (clr)
    (!pulse && cnt_en && cnt_up) |=> count == $past(count) + 1'b1)
    else $error("up step wrong");
  p_down_r3: assert property (@(posedge clk) disable iff (clr)
    (!pulse && cnt_en && !cnt_up) |=> count == $past(count) - 1'b1)
    else $error("down step wrong");
  p_load_r7: assert property (@(posedge clk) disable iff (clr)
    (pulse && op == OP_LOAD) |=> count == $past(preset))
    else $error("event load wrong");
endmodule

// File: rtl/evc_flags.sv
module evc_flags
  import evc_pkg::*;
(
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] ref1,
  input  logic [CNT_W-1:0] ref2,
  output logic             zero_o,
  output logic             hit1,
  output logic             hit2
);
  logic [CNT_W-1:0] refs [2];
  logic [1:0]       hits;

  assign refs[0] = ref1;
  assign refs[1] = ref2;

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    assign hits[i] = (count == refs[i]);
  end

  assign zero_o = (count == '0);
  assign hit1   = hits[0];
  assign hit2   = hits[1];
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         cnt_en,
  input  logic         cnt_up,
  input  logic         evt,
  input  logic         cfg_arith,
  input  logic         cfg_add,
  input  logic         cfg_left,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         zero_o,
  output logic         hit1,
  output logic         hit2
);
  logic         ev_pulse;
  ev_op_t       ev_op;
  logic [W-1:0] preset, ref1, ref2;

  assign ev_op = decode_op(cfg_arith, cfg_add, cfg_left);

  evc_edge u_edge (
    .clk(clk), .clr(clr), .evt(evt), .pulse(ev_pulse)
  );

  evc_regs u_regs (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .preset(preset), .ref1(ref1), .ref2(ref2)
  );

  evc_core u_core (
    .clk(clk), .clr(clr), .cnt_en(cnt_en), .cnt_up(cnt_up), .pulse(ev_pulse),
    .op(ev_op), .preset(preset), .count(count)
  );

  evc_flags u_flags (
    .count(count), .ref1(ref1), .ref2(ref2),
    .zero_o(zero_o), .hit1(hit1), .hit2(hit2)
  );
endmodule

// File: tb/evc_counter_test.sv
`timescale 1ns/1ps
module evc_counter_test;
  logic        clk = 0;
  logic        clr = 1;
  logic        cnt_en = 0, cnt_up = 0, evt = 0;
  logic        cfg_arith = 0, cfg_add = 0, cfg_left = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] count;
  logic        zero_o, hit1, hit2;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] REF1 = 32'd5;
  localparam logic [31:0] REF2 = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  evc_counter uut (
    .clk(clk), .clr(clr), .cnt_en(cnt_en), .cnt_up(cnt_up), .evt(evt),
    .cfg_arith(cfg_arith), .cfg_add(cfg_add), .cfg_left(cfg_left),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .zero_o(zero_o), .hit1(hit1), .hit2(hit2)
  );

  // {en, up, evt, arith, add, left, expected count}, preset = 4
  localparam int NV = 23;
  localparam logic [37:0] VEC [NV] = '{
    {6'b110000, 32'h1},        // R3 up
    {6'b110000, 32'h2},
    {6'b000000, 32'h2},        // R2 hold
    {6'b100000, 32'h1},        // R3 down
    {6'b100000, 32'h0},
    {6'b100000, 32'hFFFF_FFFF},// R4 down wrap
    {6'b110000, 32'h0},        // R4 up wrap
    {6'b111000, 32'h4},        // R6/R7 load overrides count
    {6'b111000, 32'h5},        // R5 held high: counts
    {6'b000000, 32'h5},
    {6'b001111, 32'h9},        // R9 add
    {6'b000000, 32'h9},
    {6'b001110, 32'h5},        // R9 sub
    {6'b000000, 32'h5},
    {6'b001101, 32'h50},       // R8 shl 4
    {6'b000000, 32'h50},
    {6'b001100, 32'h5},        // R8 shr 4
    {6'b000000, 32'h5},
    {6'b001110, 32'h1},
    {6'b000000, 32'h1},
    {6'b001110, 32'hFFFF_FFFD},// R9 sub wrap
    {6'b000000, 32'hFFFF_FFFD},
    {6'b001111, 32'h1}         // R9 add wrap
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req, logic [31:0] exp, logic [31:0] r1, logic [31:0] r2);
    check(req, {29'd0, zero_o, hit1, hit2},
          {29'd0, exp == 32'd0, exp == r1, exp == r2});
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  // event with given kind, then one idle cycle; count checked after both
  task automatic fire(logic a, logic ad, logic l);
    cnt_en = 0; cfg_arith = a; cfg_add = ad; cfg_left = l; evt = 1;
    tick();
    evt = 0;
    tick();
  endtask

  initial begin
    logic [31:0] r1, r2;
    r1 = REF1; r2 = REF2;
    wr(2'd0, 32'd4);
    wr(2'd1, REF1);
    wr(2'd2, REF2);
    tick();
    check("R1 reset count", count, 32'd0);
    check_flags("R10 reset flags", 32'd0, r1, r2);
    // clear beats an event edge and enable
    cnt_en = 1; cnt_up = 1; evt = 1; cfg_arith = 0;
    tick();
    check("R1 clear priority", count, 32'd0);
    evt = 0; cnt_en = 0;
    tick();
    clr = 0;

    for (int i = 0; i < NV; i++) begin
      {cnt_en, cnt_up, evt, cfg_arith, cfg_add, cfg_left} = VEC[i][37:32];
      tick();
      check($sformatf("R3-vector %0d count", i), count, VEC[i][31:0]);
      check_flags($sformatf("R10 vector %0d flags", i), VEC[i][31:0], r1, r2);
    end
    evt = 0; cnt_en = 0;
    tick();
    check("R6 resumes after event", count, 32'h1);

    // R11: same-cycle preset write and load event use old preset
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'd100; cfg_arith = 0; evt = 1;
    tick();
    wr_en = 0; evt = 0;
    check("R11 old preset on same-cycle write", count, 32'd4);
    tick();
    fire(0, 0, 0);
    check("R11 new preset loaded", count, 32'd100);

    // R11: select 3 ignored
    wr(2'd3, 32'd77);
    fire(0, 0, 0);
    check("R11 sel3 leaves preset", count, 32'd100);
    check_flags("R11 sel3 leaves refs", count, r1, r2);

    // R10/R11: run-time reference change
    wr(2'd1, 32'd100); r1 = 32'd100;
    check("R10 hit1 after ref1 write", {31'd0, hit1}, 32'd1);
    wr(2'd2, 32'd100); r2 = 32'd100;
    check("R10 hit2 after ref2 write", {31'd0, hit2}, 32'd1);

    // R8: shifts by 31 and by 0
    wr(2'd0, 32'd31);
    fire(0, 0, 0);
    check("R7 load 31", count, 32'd31);
    fire(1, 0, 1);
    check("R8 shl 31", count, 32'h8000_0000);
    fire(1, 0, 0);
    check("R8 shr 31 zero fill", count, 32'h1);
    wr(2'd0, 32'h20);
    fire(1, 0, 1);
    check("R8 shift amount low bits only", count, 32'h1);
    fire(1, 1, 1);
    check("R9 add uses full preset", count, 32'h21);

    // R1 mid-run clear
    clr = 1; cnt_en = 1; cnt_up = 1;
    tick();
    check("R1 clear while enabled", count, 32'd0);
    check("R10 zero after clear", {31'd0, zero_o}, 32'd1);
    clr = 0;
    tick();
    check("R3 counts after clear release", count, 32'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule